// File: doc/BRIEF.md
# Write-Ready Sequencer for a Split-Phase Bus Target

This block sits in the target of a pipelined processor bus whose transactions complete in request order. It keeps a small in-order queue of outstanding transactions. Each entry records whether the request carries write data, whether that write is zero length, how many clocks have passed since the request, and, once the snoop result arrives, whether a snooping cache will push a modified line back. From that record and from the state of the transaction at the head of the queue, the block decides the cycle in which the target-ready output rises and the cycle in which it falls.

A transaction can need up to two ready handshakes. The first is for the initiator's own write data. The second is for the snooper's implicit-writeback line. The block orders them, keeps the output low for at least one clock between them, waits for buffer space, and spaces successive releases far enough apart for the data-busy handshake to be sampled. A response for the head entry pops the queue and always ends any ready that is still open.

Top module: `bus_wrdy_ctrl`

## Requirements
- R1: After a synchronous reset, `trdy` and `ovf_err` are low and the queue is empty.
- R2: For a write handshake, `trdy` rises only for the head entry, only while `wbuf_free` is high, and no earlier than the third clock after the cycle in which `req_vld` was high for that entry.
- R3: `trdy` for a transaction never rises while an older entry is still queued. Once the response for the older entry has been seen (`rsp_drv` high), `trdy` for the new head rises one clock later at the earliest.
- R4: A write flagged zero length at request time still receives a write handshake, and that handshake does not wait for `wbuf_free`.
- R5: An implicit-writeback handshake starts only after the snoop result has marked the entry with `snp_iwb` = 1, and only while `lbuf_free` is high.
- R6: When an entry has both write data and an implicit writeback, the write handshake completes first. `trdy` is then low for at least one clock before the writeback handshake begins.
- R7: An open handshake is released when `dbsy` is sampled low while `trdy` is high, including the first clock of `trdy`. While `dbsy` stays high and no response arrives, `trdy` stays high.
- R8: Two consecutive high-to-low transitions of `trdy` are at least three clocks apart.
- R9: `rsp_drv` pops the head entry and releases an open `trdy` on the next clock, whatever the state of `dbsy`.
- R10: A request that arrives with 8 entries already queued is discarded, and `ovf_err` goes high and stays high until reset.
- R11: An entry with no write data whose snoop result carries no writeback never causes `trdy` to rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe; pushes one entry |
| req_has_wr | input | 1 | Request carries initiator write data |
| req_zero_len | input | 1 | Write length is zero |
| snp_vld | input | 1 | Snoop result valid for the oldest entry not yet snooped |
| snp_iwb | input | 1 | Snoop result: implicit writeback will follow |
| wbuf_free | input | 1 | A write-data buffer is available |
| lbuf_free | input | 1 | A cache-line buffer is available |
| dbsy | input | 1 | Data bus busy |
| rsp_drv | input | 1 | Response is driven for the head entry this clock |
| trdy | output | 1 | Target ready (registered) |
| ovf_err | output | 1 | Sticky queue overflow |

## Verification
A stale age or a lost snoop flag in the queue shows up as a `trdy` rise that comes too early or never comes. A random run against a cycle model in the bench catches that on the clock where the rise should have happened. A wrong head pointer hands ready to the wrong transaction, which shows up as a rise before the older response or a missing rise after it, one clock after the pop. A spacing counter that does not clear shows up as a writeback ready that closes after one cycle instead of two, or as a gap of fewer than three clocks between falls, within three clocks of the first release.

// File: rtl/wrdy_pkg.sv
package wrdy_pkg;
  // Flags captured for one outstanding transaction
  typedef struct packed {
    logic has_wr;  // initiator supplies write data
    logic zlen;    // zero-length write
    logic iwb;     // snoop reported an implicit writeback
  } wrdy_ent_t;
endpackage

// File: rtl/wrdy_ioq.sv
// In-order queue: per-entry flags and a saturating age. DEPTH must be a power of two.
module wrdy_ioq
  import wrdy_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int AGE_W   = 2,
  parameter int AGE_MAX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             push_wr,
  input  logic             push_zl,
  input  logic             snp_vld,
  input  logic             snp_iwb,
  input  logic             pop,
  output logic             hd_vld,
  output wrdy_ent_t        hd_ent,
  output logic             hd_snooped,
  output logic [AGE_W-1:0] hd_age,
  output logic             ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  wrdy_ent_t        ent_q [DEPTH];
  logic [AGE_W-1:0] age_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, snp_idx;
  logic [CNT_W-1:0] cnt, snp_cnt;
  logic             ovf_q;
  logic             push_ok, pop_ok, snp_ok;

  assign push_ok = push && (cnt != CNT_W'(DEPTH));
  assign pop_ok  = pop && (cnt != '0);
  assign snp_ok  = snp_vld && (snp_cnt < cnt);
  assign snp_idx = rd_ptr + snp_cnt[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_q[i] <= '0;
        age_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_ok && wr_ptr == PTR_W'(i)) begin
          ent_q[i] <= '{has_wr: push_wr, zlen: push_zl, iwb: 1'b0};
          age_q[i] <= AGE_W'(1);
        end else begin
          if (snp_ok && snp_idx == PTR_W'(i)) ent_q[i].iwb <= snp_iwb;
          if (age_q[i] != AGE_W'(AGE_MAX)) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      cnt     <= '0;
      snp_cnt <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      cnt     <= cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
      snp_cnt <= snp_cnt + CNT_W'(snp_ok) - CNT_W'(pop_ok && snp_cnt != '0);
      if (push && !push_ok) ovf_q <= 1'b1;
    end
  end

  assign hd_vld     = (cnt != '0);
  assign hd_ent     = ent_q[rd_ptr];
  assign hd_age     = age_q[rd_ptr];
  assign hd_snooped = (snp_cnt != '0);
  assign ovf        = ovf_q;

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst) ovf_q |=> ovf_q)
    else $error("overflow flag cleared without reset");
  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> ($past(push) && $past(cnt) == CNT_W'(DEPTH)))
    else $error("overflow raised without a push into a full queue");
endmodule

// File: rtl/wrdy_gap.sv
// Clocks since the last release of target-ready, saturating.
module wrdy_gap #(
  parameter int SPACE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fall,
  output logic gap_ok
);
  localparam int CW = $clog2(SPACE + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= CW'(SPACE);
    else if (fall)                cnt_q <= '0;
    else if (cnt_q != CW'(SPACE)) cnt_q <= cnt_q + 1'b1;
  end

  // a release decided now shows on the output one clock later
  assign gap_ok = (cnt_q >= CW'(SPACE - 1));
endmodule

// File: rtl/wrdy_seq.sv
// Handshake sequencer: write ready first, then writeback ready.
module wrdy_seq
  import wrdy_pkg::*;
#(
  parameter int AGE_W   = 2,
  parameter int MIN_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hd_vld,
  input  wrdy_ent_t        hd_ent,
  input  logic             hd_snooped,
  input  logic [AGE_W-1:0] hd_age,
  input  logic             wbuf_free,
  input  logic             lbuf_free,
  input  logic             dbsy,
  input  logic             rsp,
  input  logic             gap_ok,
  output logic             trdy,
  output logic             fall
);
  logic trdy_q, cur_iwb_q, wr_done_q, iwb_done_q;
  logic wr_ok, iwb_ok, rel, start_wr, start_iwb;
  logic hd_has_wr;

  assign hd_has_wr = hd_ent.has_wr;

  assign wr_ok  = hd_vld && hd_has_wr && !wr_done_q &&
                  (hd_ent.zlen || wbuf_free) &&
                  (hd_age >= AGE_W'(MIN_LAT - 1));
  assign iwb_ok = hd_vld && hd_snooped && hd_ent.iwb && !iwb_done_q &&
                  lbuf_free && (!hd_has_wr || wr_done_q);

  assign start_wr  = !trdy_q && !rsp && wr_ok;
  assign start_iwb = !trdy_q && !rsp && !wr_ok && iwb_ok;
  assign rel       = trdy_q && (rsp || (!dbsy && gap_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      trdy_q     <= 1'b0;
      cur_iwb_q  <= 1'b0;
      wr_done_q  <= 1'b0;
      iwb_done_q <= 1'b0;
    end else begin
      if (start_wr || start_iwb) begin
        trdy_q    <= 1'b1;
        cur_iwb_q <= start_iwb;
      end else if (rel) begin
        trdy_q <= 1'b0;
      end
      if (rsp) begin
        wr_done_q  <= 1'b0;
        iwb_done_q <= 1'b0;
      end else if (rel) begin
        if (cur_iwb_q) iwb_done_q <= 1'b1;
        else           wr_done_q  <= 1'b1;
      end
    end
  end

  assign trdy = trdy_q;
  assign fall = rel;

  // cycles since reset, for the look-back in the spacing check
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                 warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
  end

  // R2
  wr_age_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(trdy_q) && !cur_iwb_q) |->
      ($past(hd_vld) && $past(hd_age) >= AGE_W'(MIN_LAT - 1)))
    else $error("write ready before minimum latency");
  // R3
  rsp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trdy_q) |-> !$past(rsp))
    else $error("ready raised in the response clock");
  // R6
  order_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(trdy_q) && cur_iwb_q) |->
      ($past(hd_snooped) && (!$past(hd_has_wr) || $past(wr_done_q))))
    else $error("writeback ready out of order");
  // R8
  spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd3 && $fell(trdy_q)) |->
      !(!$past(trdy_q, 2) && $past(trdy_q, 3)))
    else $error("ready releases too close together");
  // R9
  rsp_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp && trdy_q) |=> !trdy_q)
    else $error("ready held past the response");
endmodule

// File: rtl/bus_wrdy_ctrl.sv
module bus_wrdy_ctrl
  import wrdy_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int MIN_LAT = 3,
  parameter int SPACE   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req_vld,
  input  logic req_has_wr,
  input  logic req_zero_len,
  input  logic snp_vld,
  input  logic snp_iwb,
  input  logic wbuf_free,
  input  logic lbuf_free,
  input  logic dbsy,
  input  logic rsp_drv,
  output logic trdy,
  output logic ovf_err
);
  localparam int AGE_MAX = MIN_LAT;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);

  logic             hd_vld, hd_snooped, gap_ok, fall;
  wrdy_ent_t        hd_ent;
  logic [AGE_W-1:0] hd_age;

  wrdy_ioq #(.DEPTH(DEPTH), .AGE_W(AGE_W), .AGE_MAX(AGE_MAX)) u_ioq (
    .clk(clk), .rst(rst),
    .push(req_vld), .push_wr(req_has_wr), .push_zl(req_zero_len),
    .snp_vld(snp_vld), .snp_iwb(snp_iwb), .pop(rsp_drv),
    .hd_vld(hd_vld), .hd_ent(hd_ent), .hd_snooped(hd_snooped),
    .hd_age(hd_age), .ovf(ovf_err)
  );

  wrdy_gap #(.SPACE(SPACE)) u_gap (
    .clk(clk), .rst(rst), .fall(fall), .gap_ok(gap_ok)
  );

  wrdy_seq #(.AGE_W(AGE_W), .MIN_LAT(MIN_LAT)) u_seq (
    .clk(clk), .rst(rst),
    .hd_vld(hd_vld), .hd_ent(hd_ent), .hd_snooped(hd_snooped), .hd_age(hd_age),
    .wbuf_free(wbuf_free), .lbuf_free(lbuf_free), .dbsy(dbsy), .rsp(rsp_drv),
    .gap_ok(gap_ok), .trdy(trdy), .fall(fall)
  );
endmodule

// File: tb/tb_bus_wrdy_ctrl.sv
module tb_bus_wrdy_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int QDEPTH     = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic req_vld = 0, req_has_wr = 0, req_zero_len = 0, snp_vld = 0, snp_iwb = 0;
  logic wbuf_free = 1, lbuf_free = 1, dbsy = 0, rsp_drv = 0;
  logic trdy, ovf_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bus_wrdy_ctrl dut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_has_wr(req_has_wr),
    .req_zero_len(req_zero_len), .snp_vld(snp_vld), .snp_iwb(snp_iwb),
    .wbuf_free(wbuf_free), .lbuf_free(lbuf_free), .dbsy(dbsy),
    .rsp_drv(rsp_drv), .trdy(trdy), .ovf_err(ovf_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model of the rules ----------------
  typedef struct { bit wr; bit zl; bit snp; bit iwb; int age; } m_ent_t;
  m_ent_t mq[$];
  bit m_trdy, m_cur, m_wrd, m_iwd, m_ovf;
  int m_gap;

  function automatic bit f_wr_ok();
    return mq.size() > 0 && mq[0].wr && !m_wrd && (mq[0].zl || wbuf_free) && mq[0].age >= 2;
  endfunction
  function automatic bit f_iwb_ok();
    return mq.size() > 0 && mq[0].snp && mq[0].iwb && !m_iwd && lbuf_free &&
           (!mq[0].wr || m_wrd);
  endfunction
  function automatic bit f_rsp_ready();
    return mq.size() > 0 && mq[0].snp && (!mq[0].wr || m_wrd) &&
           (!mq[0].iwb || m_iwd) && !m_trdy;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_trdy = 0; m_cur = 0; m_wrd = 0; m_iwd = 0; m_ovf = 0; m_gap = 3;
    end else begin
      bit wo, io, rel;
      wo  = f_wr_ok();
      io  = f_iwb_ok();
      rel = m_trdy && (rsp_drv || (!dbsy && m_gap >= 2));
      if (!m_trdy && !rsp_drv && (wo || io)) begin
        m_trdy = 1; m_cur = !wo;
      end else if (rel) begin
        m_trdy = 0;
        if (m_cur) m_iwd = 1; else m_wrd = 1;
      end
      m_gap = rel ? 0 : (m_gap < 3 ? m_gap + 1 : 3);
      if (rsp_drv) begin m_wrd = 0; m_iwd = 0; end
      foreach (mq[i]) if (mq[i].age < 3) mq[i].age++;
      if (snp_vld) begin
        for (int i = 0; i < mq.size(); i++)
          if (!mq[i].snp) begin mq[i].snp = 1; mq[i].iwb = snp_iwb; break; end
      end
      if (rsp_drv && mq.size() > 0) void'(mq.pop_front());
      if (req_vld) begin
        if (mq.size() < QDEPTH) mq.push_back('{req_has_wr, req_zero_len, 1'b0, 1'b0, 1});
        else m_ovf = 1;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every clock: outputs against the rule model (R2 R3 R5 R6 R7 R8 R9 R10 R11)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(trdy == m_trdy, "R8 model trdy", trdy, m_trdy);
      chk(ovf_err == m_ovf, "R10 model ovf", ovf_err, m_ovf);
    end
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic do_reset();
    rst = 1; repeat (3) cyc(); rst = 0;
  endtask
  task automatic push(input bit wr, input bit zl);
    req_vld = 1; req_has_wr = wr; req_zero_len = zl; cyc(); req_vld = 0;
  endtask
  task automatic snoop(input bit iwb);
    snp_vld = 1; snp_iwb = iwb; cyc(); snp_vld = 0;
  endtask
  task automatic respond();
    rsp_drv = 1; cyc(); rsp_drv = 0;
  endtask

  function automatic bit pct(input int p);
    return ($urandom % 100) < p;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1
    chk(trdy == 0, "R1 trdy after reset", trdy, 0);
    chk(ovf_err == 0, "R1 ovf after reset", ovf_err, 0);

    // R2 / R7: single write, minimum latency, release on idle data bus
    push(1, 0);
    chk(trdy == 0, "R2 one clock after request", trdy, 0);
    cyc(); chk(trdy == 0, "R2 two clocks after request", trdy, 0);
    cyc(); chk(trdy == 1, "R2 third clock after request", trdy, 1);
    cyc(); chk(trdy == 0, "R7 release with dbsy low", trdy, 0);
    snoop(0); respond();

    // R3: second write waits for the first response
    req_vld = 1; req_has_wr = 1; req_zero_len = 0; cyc(); cyc(); req_vld = 0;
    cyc(); chk(trdy == 1, "R3 first write ready", trdy, 1);
    cyc(); chk(trdy == 0, "R3 first write released", trdy, 0);
    snoop(0); snoop(0);
    repeat (3) begin cyc(); chk(trdy == 0, "R3 younger entry waits", trdy, 0); end
    respond();
    chk(trdy == 0, "R3 no ready in the response clock", trdy, 0);
    cyc(); chk(trdy == 1, "R3 ready one clock after response", trdy, 1);
    cyc(); respond();

    // R2: write waits for buffer
    wbuf_free = 0; push(1, 0);
    repeat (4) begin cyc(); chk(trdy == 0, "R2 no write buffer", trdy, 0); end
    wbuf_free = 1; cyc(); chk(trdy == 1, "R2 buffer freed", trdy, 1);
    cyc(); snoop(0); respond();

    // R4: zero-length write ignores the write buffer
    wbuf_free = 0; push(1, 1);
    cyc(); cyc(); chk(trdy == 1, "R4 zero-length ready", trdy, 1);
    cyc(); chk(trdy == 0, "R4 zero-length released", trdy, 0);
    wbuf_free = 1; snoop(0); respond();

    // R6 / R8: write then writeback
    push(1, 0); snoop(1);
    cyc(); chk(trdy == 1, "R6 write ready first", trdy, 1);
    cyc(); chk(trdy == 0, "R6 low clock between handshakes", trdy, 0);
    cyc(); chk(trdy == 1, "R6 writeback ready", trdy, 1);
    cyc(); chk(trdy == 1, "R8 release held for spacing", trdy, 1);
    cyc(); chk(trdy == 0, "R8 release after spacing", trdy, 0);
    respond();

    // R5: writeback only, waits for a line buffer
    lbuf_free = 0; push(0, 0); snoop(1);
    repeat (4) begin cyc(); chk(trdy == 0, "R5 no line buffer", trdy, 0); end
    lbuf_free = 1; cyc(); chk(trdy == 1, "R5 line buffer freed", trdy, 1);
    cyc(); chk(trdy == 0, "R5 writeback released", trdy, 0);
    respond();

    // R11: nothing to move
    push(0, 0); snoop(0);
    repeat (5) begin cyc(); chk(trdy == 0, "R11 no data, no ready", trdy, 0); end
    respond();

    // R7 / R9: data bus busy holds ready, response ends it
    dbsy = 1; push(1, 0); snoop(0);
    cyc(); chk(trdy == 1, "R7 ready under busy", trdy, 1);
    repeat (3) begin cyc(); chk(trdy == 1, "R7 held while busy", trdy, 1); end
    respond();
    chk(trdy == 0, "R9 response releases ready", trdy, 0);
    dbsy = 0;
    repeat (4) begin cyc(); chk(trdy == 0, "R9 head popped", trdy, 0); end

    // R10: overflow discards the ninth request
    for (int i = 0; i < QDEPTH; i++) push(0, 0);
    chk(ovf_err == 0, "R10 full but no overflow", ovf_err, 0);
    push(1, 0);
    chk(ovf_err == 1, "R10 overflow raised", ovf_err, 1);
    for (int i = 0; i < QDEPTH; i++) snoop(0);
    for (int i = 0; i < QDEPTH; i++) respond();
    repeat (6) begin cyc(); chk(trdy == 0, "R10 discarded write never readied", trdy, 0); end
    chk(ovf_err == 1, "R10 overflow sticky", ovf_err, 1);

    // random traffic against the model
    do_reset();
    chk(ovf_err == 0, "R1 overflow cleared by reset", ovf_err, 0);
    for (int n = 0; n < 4000; n++) begin
      bit unsnooped;
      unsnooped = 0;
      foreach (mq[i]) if (!mq[i].snp) unsnooped = 1;
      req_vld      = (mq.size() < QDEPTH) && pct(25);
      req_has_wr   = pct(55);
      req_zero_len = pct(20);
      snp_vld      = unsnooped && pct(35);
      snp_iwb      = pct(35);
      wbuf_free    = pct(75);
      lbuf_free    = pct(70);
      dbsy         = pct(35);
      rsp_drv      = f_rsp_ready() && pct(50);
      cyc();
    end
    req_vld = 0; snp_vld = 0; rsp_drv = 0; dbsy = 0;
    cyc();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule